// File: doc/BRIEF.md
# Prescaled Seconds Counter with Compare Alarms

A register-mapped timekeeping peripheral that keeps a 32-bit count of sixteenth-second units. It sits on the system clock and receives the slow reference as a one-cycle enable pulse, `tick32k_en`, at nominally 32.768 kHz. A programmable prescaler turns these pulses into count steps. Bits [3:0] of the count are the sub-second fraction and bits [31:4] are whole seconds. Software keeps track of wraps beyond 32 bits, using a scratch register that the hardware never touches.

Two compare registers raise alarm events. A per-step "tick" event is also available. One status word holds sticky event flags that are cleared by writing 1, next to plain read/write enable bits. The single interrupt output is active whenever an enabled event is pending. Bus access has no wait states: a write takes effect at the clock edge where `bus_wr` is high. Read data is valid in the same cycle that `bus_rd` is high.

Top module: `rtc_timebase`

## Requirements
- R1: After reset, every mapped register reads 0 and `irq` is 0.
- R2: While clock-select holds 3, the counter advances by exactly 1 on every 2×(DIV+1)-th `tick32k_en` pulse, where DIV is the divider register. With DIV = 1023 this gives 16 steps per second.
- R3: The clock-select register at offset 0x1C stores and reads back bits [1:0] of the written value. Any value other than 3 freezes both the counter and the prescaler.
- R4: A write to offset 0x00 loads all 32 counter bits and restarts the prescaler. Counting then resumes from the loaded value, and a step that would fall in the same cycle is dropped.
- R5: A write to the divider at offset 0x0C restarts the prescaler. The new period applies from that point on.
- R6: The status word at offset 0x08 has these bits: bit0 alarm-0 event, bit1 tick event, bit2 alarm-0 enable, bit3 tick enable, bit4 alarm-1 event, bit6 alarm-1 enable. All other bits read 0. Writing 1 to an event bit clears it and writing 0 leaves it unchanged. Enable bits take the written value.
- R7: On a step whose new counter value equals alarm 0 (offset 0x04) or alarm 1 (offset 0x18), the matching event bit sets, provided that alarm's enable bit is 1 before the step.
- R8: The tick event bit sets on every step while the tick enable bit is 1.
- R9: When a hardware set and a write-1 clear reach the same event bit in the same cycle, the bit ends up set.
- R10: `irq` is 1 exactly when at least one event bit is set together with its own enable bit.
- R11: The scratch register at offset 0x40 holds any 32-bit value written to it and has no effect on counting.
- R12: Reads of unmapped offsets return 0. `bus_rdata` is 0 in any cycle where `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick32k_en | input | 1 | One-cycle pulse per slow reference period |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as `bus_rd` |
| irq | output | 1 | Interrupt, active high |

## Verification
The bench keeps a write-1-to-clear on the tick event asserted for many back-to-back cycles while steps fall inside that window. A design that lets the clear win would lose a tick event and drop `irq` right after a step. It loads the counter just below the 32-bit wrap with alarm 0 at zero, which catches a comparison against the old count instead of the new one, or a missed wrap. It also changes the divider in the middle of a period and parks the clock select on a reserved value. A prescaler that is not restarted, or that keeps running while halted, then steps at the wrong cycle, and the per-cycle comparison with the reference model flags that cycle.

// File: rtl/rtc_timebase_pkg.sv
package rtc_timebase_pkg;

  localparam int NUM_AL = 2;

  // register byte offsets
  localparam int OFF_CNT  = 'h00;
  localparam int OFF_STAT = 'h08;
  localparam int OFF_DIV  = 'h0C;
  localparam int OFF_CSEL = 'h1C;
  localparam int OFF_SCR  = 'h40;
  localparam int AL_OFF    [NUM_AL] = '{'h04, 'h18};

  // status word bit positions
  localparam int ST_HZ_EV = 1;
  localparam int ST_HZ_EN = 3;
  localparam int AL_EV_BIT [NUM_AL] = '{0, 4};
  localparam int AL_EN_BIT [NUM_AL] = '{2, 6};

  localparam int        CSEL_W   = 2;
  localparam logic [1:0] CSEL_RUN = 2'd3;

  typedef struct packed {
    logic cnt;
    logic stat;
    logic div;
    logic csel;
    logic scr;
  } wr_dec_t;

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             step
);
  localparam int PRE_W = DIV_W + 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] limit;
  logic             at_lim;
  logic             adv;

  // period is 2*(div+1) pulses: count 0 .. 2*div+1
  assign limit  = {div, 1'b1};
  assign at_lim = (pre_q == limit);
  assign adv    = tick_en & run;
  assign step   = adv & at_lim & ~restart;

  always_comb begin
    pre_d = pre_q;
    if (restart)     pre_d = '0;
    else if (adv)    pre_d = at_lim ? '0 : pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int DATA_W = 32,
  parameter int NUM_AL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              step,
  input  logic [DATA_W-1:0] alarm [NUM_AL],
  output logic [DATA_W-1:0] cnt_q,
  output logic [NUM_AL-1:0] al_hit
);
  logic [DATA_W-1:0] cnt_inc;
  logic [DATA_W-1:0] cnt_d;

  assign cnt_inc = cnt_q + DATA_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (step) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // compare against the value the counter is about to take
  for (genvar i = 0; i < NUM_AL; i++) begin : g_match
    assign al_hit[i] = step & (cnt_inc == alarm[i]);
  end
endmodule

// File: rtl/rtc_status_regs.sv
module rtc_status_regs #(
  parameter int DATA_W = 32,
  parameter int NUM_AL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step,
  input  logic [NUM_AL-1:0] al_hit,
  output logic [DATA_W-1:0] status,
  output logic              irq
);
  import rtc_timebase_pkg::*;

  logic [NUM_AL-1:0] al_ev_q, al_ev_d, al_en_q, al_en_d;
  logic              hz_ev_q, hz_ev_d, hz_en_q, hz_en_d;
  logic [NUM_AL-1:0] al_pend;

  for (genvar i = 0; i < NUM_AL; i++) begin : g_al
    logic set_i, clr_i;
    assign set_i      = al_hit[i] & al_en_q[i];
    assign clr_i      = wr & wdata[AL_EV_BIT[i]];
    assign al_ev_d[i] = set_i | (al_ev_q[i] & ~clr_i);
    assign al_en_d[i] = wr ? wdata[AL_EN_BIT[i]] : al_en_q[i];
    assign al_pend[i] = al_ev_q[i] & al_en_q[i];
  end

  always_comb begin
    hz_ev_d = (step & hz_en_q) | (hz_ev_q & ~(wr & wdata[ST_HZ_EV]));
    hz_en_d = wr ? wdata[ST_HZ_EN] : hz_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_ev_q <= '0;
      al_en_q <= '0;
      hz_ev_q <= 1'b0;
      hz_en_q <= 1'b0;
    end else begin
      al_ev_q <= al_ev_d;
      al_en_q <= al_en_d;
      hz_ev_q <= hz_ev_d;
      hz_en_q <= hz_en_d;
    end
  end

  always_comb begin
    status = '0;
    status[ST_HZ_EV] = hz_ev_q;
    status[ST_HZ_EN] = hz_en_q;
    for (int i = 0; i < NUM_AL; i++) begin
      status[AL_EV_BIT[i]] = al_ev_q[i];
      status[AL_EN_BIT[i]] = al_en_q[i];
    end
  end

  assign irq = (|al_pend) | (hz_ev_q & hz_en_q);
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick32k_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import rtc_timebase_pkg::*;

  logic              rst_n_s;
  wr_dec_t           wdec;
  logic [NUM_AL-1:0] wr_al;
  logic [DATA_W-1:0] al_q [NUM_AL];
  logic [DATA_W-1:0] al_d [NUM_AL];
  logic [DIV_W-1:0]  div_q, div_d;
  logic [CSEL_W-1:0] csel_q, csel_d;
  logic [DATA_W-1:0] scr_q, scr_d;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] status_w;
  logic [NUM_AL-1:0] al_hit;
  logic              run;
  logic              step;
  logic [DATA_W-1:0] rd_mux;

  rtc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  // write decode
  always_comb begin
    wdec.cnt  = bus_wr & (bus_addr == ADDR_W'(OFF_CNT));
    wdec.stat = bus_wr & (bus_addr == ADDR_W'(OFF_STAT));
    wdec.div  = bus_wr & (bus_addr == ADDR_W'(OFF_DIV));
    wdec.csel = bus_wr & (bus_addr == ADDR_W'(OFF_CSEL));
    wdec.scr  = bus_wr & (bus_addr == ADDR_W'(OFF_SCR));
  end

  for (genvar i = 0; i < NUM_AL; i++) begin : g_alreg
    assign wr_al[i] = bus_wr & (bus_addr == ADDR_W'(AL_OFF[i]));
    assign al_d[i]  = wr_al[i] ? bus_wdata : al_q[i];
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) al_q[i] <= '0;
      else          al_q[i] <= al_d[i];
    end
  end

  always_comb begin
    div_d  = wdec.div  ? bus_wdata[DIV_W-1:0]  : div_q;
    csel_d = wdec.csel ? bus_wdata[CSEL_W-1:0] : csel_q;
    scr_d  = wdec.scr  ? bus_wdata             : scr_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      div_q  <= '0;
      csel_q <= '0;
      scr_q  <= '0;
    end else begin
      div_q  <= div_d;
      csel_q <= csel_d;
      scr_q  <= scr_d;
    end
  end

  assign run = (csel_q == CSEL_RUN);

  rtc_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n_s), .tick_en(tick32k_en), .run(run),
    .restart(wdec.cnt | wdec.div), .div(div_q), .step(step)
  );

  rtc_count_core #(.DATA_W(DATA_W), .NUM_AL(NUM_AL)) u_core (
    .clk(clk), .rst_n(rst_n_s), .load(wdec.cnt), .load_val(bus_wdata),
    .step(step), .alarm(al_q), .cnt_q(cnt_q), .al_hit(al_hit)
  );

  rtc_status_regs #(.DATA_W(DATA_W), .NUM_AL(NUM_AL)) u_stat (
    .clk(clk), .rst_n(rst_n_s), .wr(wdec.stat), .wdata(bus_wdata),
    .step(step), .al_hit(al_hit), .status(status_w), .irq(irq)
  );

  // read mux
  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFF_CNT))  rd_mux = cnt_q;
    if (bus_addr == ADDR_W'(OFF_STAT)) rd_mux = status_w;
    if (bus_addr == ADDR_W'(OFF_DIV))  rd_mux = DATA_W'(div_q);
    if (bus_addr == ADDR_W'(OFF_CSEL)) rd_mux = DATA_W'(csel_q);
    if (bus_addr == ADDR_W'(OFF_SCR))  rd_mux = scr_q;
    for (int i = 0; i < NUM_AL; i++)
      if (bus_addr == ADDR_W'(AL_OFF[i])) rd_mux = al_q[i];
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;
endmodule

// File: rtl/rtc_timebase_chk.sv
module rtc_timebase_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] cnt_q,
  input logic              run,
  input logic              step,
  input logic [DATA_W-1:0] status,
  input logic              irq
);
  import rtc_timebase_pkg::*;

  logic cnt_wr, st_wr;
  assign cnt_wr = bus_wr & (bus_addr == ADDR_W'(OFF_CNT));
  assign st_wr  = bus_wr & (bus_addr == ADDR_W'(OFF_STAT));

  // R2: without a load the count moves by at most one
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + DATA_W'(1)));

  // R3: halted source freezes the count
  a_r3_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt_q));

  // R4: load takes the whole word
  a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(bus_wdata));

  // R6: write-1 clears the tick event when no step competes
  a_r6_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && bus_wdata[ST_HZ_EV] && !step) |=> !status[ST_HZ_EV]);

  // R9: set beats a simultaneous clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (step && status[ST_HZ_EN]) |=> status[ST_HZ_EV]);

  // R10: no interrupt without a pending event
  a_r10_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[AL_EV_BIT[0]] || status[AL_EV_BIT[1]] || status[ST_HZ_EV]) |-> !irq);
endmodule

bind rtc_timebase rtc_timebase_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cnt_q(cnt_q), .run(run), .step(step),
  .status(status_w), .irq(irq)
);

// File: tb/tb_rtc_timebase.sv
module tb_rtc_timebase;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick32k_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    live = 1'b0;
  string phase_tag = "";

  rtc_timebase dut (
    .clk(clk), .rst_n(rst_n), .tick32k_en(tick32k_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cnt, m_al0, m_al1, m_scr;
  int          m_div, m_csel, m_pre;
  bit          m_ev0, m_ev1, m_evh, m_en0, m_en1, m_enh;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_al0 = 0; m_al1 = 0; m_scr = 0;
      m_div = 0; m_csel = 0; m_pre = 0;
      m_ev0 = 0; m_ev1 = 0; m_evh = 0; m_en0 = 0; m_en1 = 0; m_enh = 0;
    end else begin
      bit wc, wdv, ws, run, stp, s0, s1, sh;
      int lim;
      logic [31:0] nxt;
      wc  = bus_wr && bus_addr == 8'h00;
      wdv = bus_wr && bus_addr == 8'h0C;
      ws  = bus_wr && bus_addr == 8'h08;
      run = (m_csel == 3);
      lim = 2 * (m_div + 1) - 1;
      stp = tick32k_en && run && (m_pre == lim) && !wc && !wdv;
      nxt = m_cnt + 32'd1;
      s0 = stp && m_en0 && (nxt == m_al0);
      s1 = stp && m_en1 && (nxt == m_al1);
      sh = stp && m_enh;
      m_ev0 = s0 || (m_ev0 && !(ws && bus_wdata[0]));
      m_evh = sh || (m_evh && !(ws && bus_wdata[1]));
      m_ev1 = s1 || (m_ev1 && !(ws && bus_wdata[4]));
      if (ws) begin m_en0 = bus_wdata[2]; m_enh = bus_wdata[3]; m_en1 = bus_wdata[6]; end
      if (wc || wdv) m_pre = 0;
      else if (tick32k_en && run) m_pre = (m_pre == lim) ? 0 : m_pre + 1;
      if (wc) m_cnt = bus_wdata;
      else if (stp) m_cnt = nxt;
      if (bus_wr && bus_addr == 8'h04) m_al0 = bus_wdata;
      if (bus_wr && bus_addr == 8'h18) m_al1 = bus_wdata;
      if (wdv) m_div = int'(bus_wdata[15:0]);
      if (bus_wr && bus_addr == 8'h1C) m_csel = int'(bus_wdata[1:0]);
      if (bus_wr && bus_addr == 8'h40) m_scr = bus_wdata;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] st;
    st = '0;
    st[0] = m_ev0; st[1] = m_evh; st[2] = m_en0; st[3] = m_enh;
    st[4] = m_ev1; st[6] = m_en1;
    case (a)
      8'h00: return m_cnt;
      8'h04: return m_al0;
      8'h08: return st;
      8'h0C: return 32'(m_div);
      8'h18: return m_al1;
      8'h1C: return 32'(m_csel);
      8'h40: return m_scr;
      default: return '0;
    endcase
  endfunction

  function automatic string addr_tag(input logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04, 8'h18: return "R7";
      8'h08: return "R6";
      8'h0C: return "R5";
      8'h1C: return "R3";
      8'h40: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, sampled at the falling edge
  always @(negedge clk) begin
    if (live) begin
      string t;
      bit    mirq;
      t = (phase_tag != "") ? phase_tag : (bus_rd ? addr_tag(bus_addr) : "R12");
      check(t, bus_rdata, bus_rd ? m_read(bus_addr) : 32'h0);
      mirq = (m_ev0 && m_en0) || (m_ev1 && m_en1) || (m_evh && m_enh);
      check("R10", {31'h0, irq}, {31'h0, mirq});
    end
  end

  // slow reference: one pulse every third clock
  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #2;
      tick32k_en = (k % 3 == 2);
      k++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      bus_wr = 0; bus_rd = 0;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
    @(posedge clk); #2;
    bus_wr = 0;
  endtask

  task automatic wr_hold(input logic [7:0] a, input logic [31:0] d, input int n);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(posedge clk); #2;
    bus_addr = a; bus_rd = 1; bus_wr = 0;
    @(negedge clk);
    v = bus_rdata;
    @(posedge clk); #2;
    bus_rd = 0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, e);
  endtask

  task automatic poll(input int n);
    logic [31:0] v;
    for (int i = 0; i < n; i++) begin
      rd((i % 2 == 0) ? 8'h00 : 8'h08, v);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] frozen;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(4);
    live = 1'b1;

    // R1: everything reads zero after reset
    rd_expect(8'h00, 32'h0, "R1");
    rd_expect(8'h04, 32'h0, "R1");
    rd_expect(8'h08, 32'h0, "R1");
    rd_expect(8'h0C, 32'h0, "R1");
    rd_expect(8'h18, 32'h0, "R1");
    rd_expect(8'h1C, 32'h0, "R1");
    rd_expect(8'h40, 32'h0, "R1");
    check("R1", {31'h0, irq}, 32'h0);

    // R12: unmapped offsets
    wr(8'h44, 32'h1234_5678);
    rd_expect(8'h44, 32'h0, "R12");
    rd_expect(8'h10, 32'h0, "R12");

    // R11: scratch retention
    wr(8'h40, 32'hDEAD_BEEF);
    rd_expect(8'h40, 32'hDEAD_BEEF, "R11");

    // R3: clock-select keeps two bits
    wr(8'h1C, 32'h7);
    rd_expect(8'h1C, 32'h3, "R3");
    wr(8'h1C, 32'h0);

    // R2, R7, R8: run with DIV=1 (4 pulses per step)
    wr(8'h0C, 32'h1);
    wr(8'h00, 32'h100);
    rd_expect(8'h00, 32'h100, "R4");
    wr(8'h04, 32'h103);
    wr(8'h18, 32'h105);
    wr(8'h08, 32'h4C);
    wr(8'h1C, 32'h3);
    poll(60);
    wr(8'h08, 32'h5F);   // clear all events, keep enables (R6)
    poll(10);

    // R9: back-to-back tick-event clears racing with steps
    phase_tag = "R9";
    wr_hold(8'h08, 32'h4E, 60);
    phase_tag = "";
    poll(10);

    // R5: divider change in mid-period
    wr(8'h0C, 32'h3);
    poll(60);
    wr(8'h0C, 32'h0);
    poll(30);

    // R3: reserved source value freezes the counter
    wr(8'h1C, 32'h2);
    rd(8'h00, frozen);
    idle(60);
    rd_expect(8'h00, frozen, "R3");
    wr(8'h1C, 32'h3);

    // R4, R7: load near wrap, alarm 0 at zero
    wr(8'h08, 32'h17);   // clear events, only alarm-0 enabled
    wr(8'h04, 32'h0);
    wr(8'h00, 32'hFFFF_FFFE);
    rd_expect(8'h00, 32'hFFFF_FFFE, "R4");
    poll(40);
    rd_expect(8'h08, m_read(8'h08), "R7");

    idle(4);
    live = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule